// File: doc/BRIEF.md
# Command Register with Self-Clearing Soft Reset

This block holds a two-bit host command register. One bit asks for a soft reset. Writing it starts an internal reset pulse of a fixed length, eight clocks by default. The pulse acts on the block as a hardware reset does, and the bit then drops back to zero by itself. The other bit is a device enable. It decides whether the chip may drive its external pins.

While the enable is clear, three things hold:
- The SRAM address and control group and the two search status lines get no output enable, so their pads float.
- The two cascade output groups are driven to zero.
- The bidirectional data bus is never allowed to drive.

The host writes through a plain write strobe. It reads the register back at any time. During a pulse the reset bit reads as one. The pad drivers themselves are outside the block. It only produces the enable and gated values for them.

Top module: `ctl_cmd_reg`

## Requirements
- R1: After hardware reset `rd_data` is all zero, `int_rst_o`, `sram_oe_o`, `stat_oe_o` and `dq_oe_o` are 0, and `lho_o`/`bho_o` are 0.
- R2: A write with `wr_data[0]`=1 while no pulse runs makes `int_rst_o` high for exactly PULSE_LEN (8) consecutive cycles, starting with the cycle after the write edge.
- R3: Once the pulse ends, `rd_data[0]` reads 0 again.
- R4: The pulse clears the enable bit: after the pulse `rd_data[1]` is 0 even if it was 1 before.
- R5: Every write made while a pulse runs is ignored. It neither lengthens the pulse nor changes the enable bit.
- R6: While `int_rst_o` is high, `rd_data[0]` reads 1.
- R7: A write with `wr_data[0]`=0 while idle loads `wr_data[1]` into the enable bit, visible on `rd_data[1]` from the next cycle. `rd_data` bits above 1 always read 0.
- R8: While the enable bit is 0, `sram_oe_o` and `stat_oe_o` are 0 (pads floating). While it is 1, both are 1.
- R9: While the enable bit is 0, `lho_o` and `bho_o` are 0. While it is 1, they equal `lho_i` and `bho_i`.
- R10: `dq_oe_o` equals `dq_drive_i` AND the enable bit.
- R11: A write with both bits set starts a pulse and leaves the enable bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 2 | Write data: bit 0 soft reset, bit 1 enable |
| rd_data | output | REG_W | Register read value |
| int_rst_o | output | 1 | Soft reset pulse, active high |
| sram_oe_o | output | 1 | Output enable for SRAM address/control pads |
| stat_oe_o | output | 1 | Output enable for the two search status pads |
| lho_i | input | LHO_W | Ungated 2-bit cascade output value |
| bho_i | input | BHO_W | Ungated 3-bit cascade output value |
| lho_o | output | LHO_W | Gated 2-bit cascade output |
| bho_o | output | BHO_W | Gated 3-bit cascade output |
| dq_drive_i | input | 1 | Core request to drive the data bus |
| dq_oe_o | output | 1 | Data bus output enable |

## Verification
The assertions take `rst_n` to be released synchronously to `clk`. They also take every input to be settled at the clock edge. The bench therefore changes `wr_en`, `wr_data` and the cascade and data-bus inputs only 1 ns after a rising edge. The pulse-length property takes for granted that a pulse always starts from the idle state. The bench covers this by starting each pulse only after the previous one has visibly ended. It also fires a second reset write mid-pulse, to show that such a write cannot restart the count.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  localparam int SRST_POS = 0;
  localparam int EN_POS   = 1;
  localparam int CMD_W    = 2;

  // A trigger is accepted only when the register is idle.
  function automatic logic pulse_accept(input logic we, input logic bit0, input logic busy);
    return we & bit0 & ~busy;
  endfunction

  // Next value of the enable bit.
  function automatic logic en_next(input logic cur, input logic we, input logic wbit,
                                   input logic start, input logic busy);
    if (start || busy) return 1'b0;
    if (we)            return wbit;
    return cur;
  endfunction
endpackage

// File: rtl/ccr_pulse.sv
module ccr_pulse #(
  parameter int PULSE_LEN = 8,
  localparam int CW = $clog2(PULSE_LEN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic start_o,
  output logic busy_o
);
  logic [CW-1:0] cnt_q;

  assign busy_o  = (cnt_q != '0);
  assign start_o = ccr_pkg::pulse_accept(1'b1, trig, busy_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (start_o) cnt_q <= CW'(PULSE_LEN);
    else if (busy_o)  cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/ccr_enable.sv
module ccr_enable (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_bit,
  input  logic start,
  input  logic busy,
  output logic en_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_o <= 1'b0;
    else        en_o <= ccr_pkg::en_next(en_o, wr_en, wr_bit, start, busy);
  end
endmodule

// File: rtl/ccr_gate.sv
module ccr_gate #(
  parameter int LHO_W = 2,
  parameter int BHO_W = 3
) (
  input  logic             en,
  input  logic [LHO_W-1:0] lho_i,
  input  logic [BHO_W-1:0] bho_i,
  input  logic             dq_drive_i,
  output logic [LHO_W-1:0] lho_o,
  output logic [BHO_W-1:0] bho_o,
  output logic             sram_oe_o,
  output logic             stat_oe_o,
  output logic             dq_oe_o
);
  assign lho_o     = en ? lho_i : '0;
  assign bho_o     = en ? bho_i : '0;
  assign sram_oe_o = en;
  assign stat_oe_o = en;
  assign dq_oe_o   = en & dq_drive_i;
endmodule

// File: rtl/ctl_cmd_reg.sv
module ctl_cmd_reg #(
  parameter int REG_W     = 32,
  parameter int PULSE_LEN = 8,
  parameter int LHO_W     = 2,
  parameter int BHO_W     = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ccr_pkg::CMD_W-1:0] wr_data,
  output logic [REG_W-1:0]         rd_data,
  output logic                     int_rst_o,
  output logic                     sram_oe_o,
  output logic                     stat_oe_o,
  input  logic [LHO_W-1:0]         lho_i,
  input  logic [BHO_W-1:0]         bho_i,
  output logic [LHO_W-1:0]         lho_o,
  output logic [BHO_W-1:0]         bho_o,
  input  logic                     dq_drive_i,
  output logic                     dq_oe_o
);
  // Named internal events, visible to the bound checker.
  logic soft_start;
  logic soft_busy;
  logic en_q;

  ccr_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .rst_n(rst_n), .trig(wr_en & wr_data[ccr_pkg::SRST_POS]),
    .start_o(soft_start), .busy_o(soft_busy)
  );

  ccr_enable u_en (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bit(wr_data[ccr_pkg::EN_POS]),
    .start(soft_start), .busy(soft_busy), .en_o(en_q)
  );

  ccr_gate #(.LHO_W(LHO_W), .BHO_W(BHO_W)) u_gate (
    .en(en_q), .lho_i(lho_i), .bho_i(bho_i), .dq_drive_i(dq_drive_i),
    .lho_o(lho_o), .bho_o(bho_o), .sram_oe_o(sram_oe_o),
    .stat_oe_o(stat_oe_o), .dq_oe_o(dq_oe_o)
  );

  assign int_rst_o = soft_busy;

  always_comb begin
    rd_data = '0;
    rd_data[ccr_pkg::SRST_POS] = soft_busy;
    rd_data[ccr_pkg::EN_POS]   = en_q;
  end
endmodule

// File: rtl/ccr_chk.sv
module ccr_chk #(
  parameter int REG_W     = 32,
  parameter int PULSE_LEN = 8,
  parameter int LHO_W     = 2,
  parameter int BHO_W     = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       wr_data,
  input logic [REG_W-1:0] rd_data,
  input logic             int_rst_o,
  input logic             sram_oe_o,
  input logic             stat_oe_o,
  input logic [LHO_W-1:0] lho_o,
  input logic [BHO_W-1:0] bho_o,
  input logic             dq_oe_o,
  input logic             soft_start,
  input logic             en_q
);
  localparam int RW = $clog2(PULSE_LEN + 2);
  logic [RW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         run_q <= '0;
    else if (int_rst_o) run_q <= (run_q == RW'(PULSE_LEN + 1)) ? run_q : run_q + 1'b1;
    else                run_q <= '0;
  end

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[0] && !int_rst_o) |=> int_rst_o);
  p_start_evt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    soft_start |=> (int_rst_o && !en_q));
  p_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!int_rst_o && run_q != '0) |-> (run_q == RW'(PULSE_LEN)));
  p_no_extend_r5: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RW'(PULSE_LEN));
  p_rd_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    int_rst_o |-> rd_data[0]);
  p_en_cleared_r4: assert property (@(posedge clk) disable iff (!rst_n)
    int_rst_o |-> !rd_data[1]);
  p_hiz_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[1] |-> (!sram_oe_o && !stat_oe_o));
  p_casc_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[1] |-> (lho_o == '0 && bho_o == '0));
  p_dq_in_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[1] |-> !dq_oe_o);
endmodule

bind ctl_cmd_reg ccr_chk #(.REG_W(REG_W), .PULSE_LEN(PULSE_LEN), .LHO_W(LHO_W), .BHO_W(BHO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
  .int_rst_o(int_rst_o), .sram_oe_o(sram_oe_o), .stat_oe_o(stat_oe_o),
  .lho_o(lho_o), .bho_o(bho_o), .dq_oe_o(dq_oe_o),
  .soft_start(soft_start), .en_q(en_q)
);

// File: tb/test_ctl_cmd_reg.sv
`timescale 1ns/1ps
module test_ctl_cmd_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_data = '0;
  logic [31:0] rd_data;
  logic        int_rst_o, sram_oe_o, stat_oe_o, dq_drive_i = 1'b0, dq_oe_o;
  logic [1:0]  lho_i = '0, lho_o;
  logic [2:0]  bho_i = '0, bho_o;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ctl_cmd_reg i_ctl_cmd_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .int_rst_o(int_rst_o), .sram_oe_o(sram_oe_o), .stat_oe_o(stat_oe_o),
    .lho_i(lho_i), .bho_i(bho_i), .lho_o(lho_o), .bho_o(bho_o),
    .dq_drive_i(dq_drive_i), .dq_oe_o(dq_oe_o)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    #1;
  endtask

  // Vector fields: {we, en_bit, lho[1:0], bho[2:0], dq_drive, expected enable}
  localparam logic [8:0] VEC [8] = '{
    {1'b1, 1'b1, 2'd3, 3'd5, 1'b1, 1'b1},
    {1'b0, 1'b0, 2'd1, 3'd2, 1'b1, 1'b1},
    {1'b1, 1'b0, 2'd2, 3'd7, 1'b1, 1'b0},
    {1'b0, 1'b1, 2'd3, 3'd7, 1'b1, 1'b0},
    {1'b1, 1'b1, 2'd2, 3'd1, 1'b0, 1'b1},
    {1'b0, 1'b0, 2'd0, 3'd4, 1'b1, 1'b1},
    {1'b1, 1'b1, 2'd1, 3'd6, 1'b1, 1'b1},
    {1'b1, 1'b0, 2'd3, 3'd3, 1'b0, 1'b0}
  };

  task automatic write_cmd(input logic [1:0] d);
    wr_en = 1'b1; wr_data = d;
    step();
    wr_en = 1'b0; wr_data = '0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int highs, lows_after;
    repeat (3) step();
    // R1 reset state
    chk("R1 rd_data", rd_data, 0);
    chk("R1 pulse", int_rst_o, 0);
    chk("R1 oe", {sram_oe_o, stat_oe_o, dq_oe_o}, 0);
    chk("R1 cascade", {lho_o, bho_o}, 0);
    rst_n = 1'b1;
    step();

    // Vector table: R7 R8 R9 R10
    foreach (VEC[k]) begin
      logic e;
      wr_en = VEC[k][8]; wr_data = {VEC[k][7], 1'b0};
      lho_i = VEC[k][6:5]; bho_i = VEC[k][4:2]; dq_drive_i = VEC[k][1];
      e = VEC[k][0];
      step();
      chk("R7 rd_data", rd_data, {30'd0, e, 1'b0});
      chk("R8 oe", {sram_oe_o, stat_oe_o}, {e, e});
      chk("R9 cascade", {lho_o, bho_o}, e ? {lho_i, bho_i} : 5'd0);
      chk("R10 dq_oe", dq_oe_o, dq_drive_i & e);
    end

    // Pulse with a write injected mid-pulse: R2 R3 R4 R5 R6
    lho_i = 2'd3; bho_i = 3'd7; dq_drive_i = 1'b1;
    write_cmd(2'b10);
    chk("R7 enable set", rd_data[1], 1);
    write_cmd(2'b01);
    highs = 1; lows_after = 0;
    chk("R2 pulse starts", int_rst_o, 1);
    chk("R6 read bit0", rd_data[0], 1);
    chk("R4 enable cleared", rd_data[1], 0);
    chk("R8 oe off in pulse", {sram_oe_o, stat_oe_o}, 0);
    for (int i = 0; i < 12; i++) begin
      if (i == 2) begin wr_en = 1'b1; wr_data = 2'b11; end
      else if (i == 4) begin wr_en = 1'b1; wr_data = 2'b10; end
      else begin wr_en = 1'b0; wr_data = 2'b00; end
      step();
      if (int_rst_o) begin
        highs++;
        chk("R6 read bit0 busy", rd_data[0], 1);
        if (lows_after != 0) chk("R5 restarted", 1, 0);
      end else lows_after++;
    end
    wr_en = 1'b0;
    chk("R2 R5 pulse length", highs, 8);
    chk("R3 bit0 cleared", rd_data[0], 0);
    chk("R4 R5 enable after pulse", rd_data[1], 0);
    chk("R9 cascade zero", {lho_o, bho_o}, 0);
    chk("R10 dq input", dq_oe_o, 0);

    // R11 both bits written together
    write_cmd(2'b10);
    write_cmd(2'b11);
    chk("R11 pulse", int_rst_o, 1);
    chk("R11 enable", rd_data[1], 0);
    repeat (9) step();
    chk("R11 after", rd_data, 0);

    // R7 enable write after pulse works; reserved bits read 0
    write_cmd(2'b10);
    chk("R7 rewrite", rd_data, 32'h2);
    chk("R8 oe on", {sram_oe_o, stat_oe_o}, 2'b11);

    // R1 hardware reset mid-operation
    rst_n = 1'b0;
    #1;
    chk("R1 hw reset", rd_data, 0);
    step();
    rst_n = 1'b1;
    step();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule